// File: doc/BRIEF.md
# Prefixed Vector Loop Sequencer

This block sits where fetch meets retire in a 64-bit in-order core. It decides whether the fetched 32-bit word is a vector prefix. It pulls the 24-bit remap field out of that prefix. It also holds a 32-bit vector state register, which records the maximum and current vector lengths, the source and destination element steps, and the sub-vector fields.

For each retired prefixed instruction, the block either keeps the program counter where it is and moves the source element step on by one, or ends the element loop, clears the step and moves the program counter past the 8-byte prefixed pair. When a prefixed instruction meets a vector length of zero, the block flags it to be skipped and moves on at once. Ordinary instructions leave the state register alone and advance the program counter by 4. The next address is offered combinationally, so fetch can use it in the same cycle.

Top module: `vloop_seq`

## Requirements
- R1: A word is a prefix (`is_prefixed`=1) only when `fetch_word[31:26]` equals 6'd1 and both `fetch_word[24]` and `fetch_word[22]` are 1. Bits are counted from the most significant bit as 0, so these are bits 0-5, 7 and 9.
- R2: `remap` is built, most significant bit first, from `fetch_word[25]`, then `fetch_word[23]`, then `fetch_word[21:0]`.
- R3: On a retire of a non-prefixed word, `pc` becomes `pc`+4 and `state` is unchanged.
- R4: State layout: `state[31:25]` holds the maximum length, `[24:18]` the length VL, `[17:11]` the source step (`src_step`), `[10:4]` the destination step, `[3:2]` the sub-vector length and `[1:0]` the sub-step. The loop changes only the source step field.
- R5: A prefixed word with VL=0 raises `skip_vl0`. On retire, `pc` becomes `pc`+8 and `state` is unchanged.
- R6: With `twin_pred`=0, the loop continues only when `dst_vec`=1.
- R7: With `twin_pred`=1, the loop continues when `src_vec` or `dst_vec` is 1.
- R8: When the loop continues and the source step is not VL-1, the step becomes step+1 modulo 128 and `next_pc` equals `pc`.
- R9: When the loop does not continue, or the step equals VL-1, the step becomes 0 and `pc` becomes `pc`+8.
- R10: `pc` and `state` change only on a clock edge with `retire`=1. A synchronous `rst` loads `init_pc` and `init_state`.
- R11: `next_pc` always shows the value `pc` will take if the current word retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_pc | input | 64 | Program counter loaded on reset |
| init_state | input | 32 | State register loaded on reset |
| fetch_word | input | 32 | First word of the instruction being retired |
| retire | input | 1 | Retire strobe; commits the update |
| src_vec | input | 1 | Source operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| twin_pred | input | 1 | Instruction is twin-predicated |
| is_prefixed | output | 1 | Word is a vector prefix |
| remap | output | 24 | Remap field gathered from the prefix |
| src_step | output | 7 | Current source element step |
| skip_vl0 | output | 1 | Prefixed instruction with VL=0, to be skipped |
| next_pc | output | 64 | Address after this retire |
| pc | output | 64 | Current program counter |
| state | output | 32 | Current vector state register |

## Verification
Plain words and near-miss words are used to separate the prefix test from the stride: a near-miss has major opcode 1 but lacks one of the two marker bits, and it must advance by 4. A single-predicated loop with a vector destination runs over VL=3 and shows holding against advancing. The same loop with only a vector source ends at once. A twin-predicated run with a vector source keeps going, which tells the two continuation rules apart. Further cases cover VL=0 skipping, a step of 127 wrapping to 0 while the program counter is held, non-retire cycles with a prefix on the bus, and the preservation of the other state fields.

// File: rtl/vloop_pkg.sv
`timescale 1ns/1ps
package vloop_pkg;
  localparam int WORD_W  = 32;
  localparam int STEP_W  = 7;
  localparam int SUB_W   = 2;
  localparam int REMAP_W = 24;
  localparam int STATE_W = 4 * STEP_W + 2 * SUB_W;
  localparam int MAJOR_W = 6;
  localparam logic [MAJOR_W-1:0] PFX_MAJOR = 6'd1;

  // packed: first member is the most significant (MSB0 bit 0)
  typedef struct packed {
    logic [STEP_W-1:0] maxlen;
    logic [STEP_W-1:0] vlen;
    logic [STEP_W-1:0] sstep;
    logic [STEP_W-1:0] dstep;
    logic [SUB_W-1:0]  sublen;
    logic [SUB_W-1:0]  substep;
  } vstate_t;
endpackage

// File: rtl/vloop_prefix_detect.sv
`timescale 1ns/1ps
module vloop_prefix_detect
  import vloop_pkg::*;
(
  input  logic [WORD_W-1:0]  word,
  output logic               is_pfx,
  output logic [REMAP_W-1:0] remap
);
  // MSB0 numbering helpers
  localparam int B_ID_A  = WORD_W - 1 - 7;
  localparam int B_ID_B  = WORD_W - 1 - 9;
  localparam int B_RM_HI = WORD_W - 1 - 6;
  localparam int B_RM_MD = WORD_W - 1 - 8;
  localparam int LOW_N   = REMAP_W - 2;

  assign is_pfx = (word[WORD_W-1 -: MAJOR_W] == PFX_MAJOR) &&
                  word[B_ID_A] && word[B_ID_B];

  assign remap[REMAP_W-1] = word[B_RM_HI];
  assign remap[REMAP_W-2] = word[B_RM_MD];
  for (genvar i = 0; i < LOW_N; i++) begin : g_low
    assign remap[i] = word[i];
  end
endmodule

// File: rtl/vloop_step_ctrl.sv
`timescale 1ns/1ps
module vloop_step_ctrl
  import vloop_pkg::*;
(
  input  vstate_t st,
  input  logic    is_pfx,
  input  logic    src_vec,
  input  logic    dst_vec,
  input  logic    twin,
  output logic    skip,
  output logic    hold_pc,
  output vstate_t st_next
);
  logic cont;
  logic at_last;

  always_comb begin
    skip    = is_pfx && (st.vlen == '0);
    cont    = twin ? (src_vec | dst_vec) : dst_vec;
    at_last = (st.sstep == st.vlen - STEP_W'(1));
    st_next = st;
    hold_pc = 1'b0;
    if (is_pfx && !skip) begin
      if (cont && !at_last) begin
        st_next.sstep = st.sstep + STEP_W'(1);
        hold_pc       = 1'b1;
      end else begin
        st_next.sstep = '0;
      end
    end
  end
endmodule

// File: rtl/vloop_pc_adv.sv
`timescale 1ns/1ps
module vloop_pc_adv #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              is_pfx,
  input  logic              hold,
  output logic [ADDR_W-1:0] npc
);
  localparam logic [ADDR_W-1:0] STRIDE_PLAIN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] STRIDE_PFX   = ADDR_W'(8);

  always_comb begin
    if (hold)        npc = pc;
    else if (is_pfx) npc = pc + STRIDE_PFX;
    else             npc = pc + STRIDE_PLAIN;
  end
endmodule

// File: rtl/vloop_seq.sv
`timescale 1ns/1ps
module vloop_seq
  import vloop_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  init_pc,
  input  logic [STATE_W-1:0] init_state,
  input  logic [WORD_W-1:0]  fetch_word,
  input  logic               retire,
  input  logic               src_vec,
  input  logic               dst_vec,
  input  logic               twin_pred,
  output logic               is_prefixed,
  output logic [REMAP_W-1:0] remap,
  output logic [STEP_W-1:0]  src_step,
  output logic               skip_vl0,
  output logic [ADDR_W-1:0]  next_pc,
  output logic [ADDR_W-1:0]  pc,
  output logic [STATE_W-1:0] state
);
  vstate_t st_q, st_d;
  logic [ADDR_W-1:0] pc_q;
  logic hold;

  vloop_prefix_detect u_det (
    .word   (fetch_word),
    .is_pfx (is_prefixed),
    .remap  (remap)
  );

  vloop_step_ctrl u_step (
    .st      (st_q),
    .is_pfx  (is_prefixed),
    .src_vec (src_vec),
    .dst_vec (dst_vec),
    .twin    (twin_pred),
    .skip    (skip_vl0),
    .hold_pc (hold),
    .st_next (st_d)
  );

  vloop_pc_adv #(.ADDR_W(ADDR_W)) u_pc (
    .pc     (pc_q),
    .is_pfx (is_prefixed),
    .hold   (hold),
    .npc    (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= init_pc;
      st_q <= vstate_t'(init_state);
    end else if (retire) begin
      pc_q <= next_pc;
      st_q <= st_d;
    end
  end

  assign pc       = pc_q;
  assign state    = st_q;
  assign src_step = st_q.sstep;
endmodule

// File: rtl/vloop_seq_chk.sv
`timescale 1ns/1ps
module vloop_seq_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              retire,
  input logic              is_prefixed,
  input logic              skip_vl0,
  input logic [6:0]        src_step,
  input logic [ADDR_W-1:0] next_pc,
  input logic [ADDR_W-1:0] pc,
  input logic [31:0]       state
);
  a_r3_plain_adv: assert property (@(posedge clk) disable iff (rst)
    retire && !is_prefixed |=> pc == $past(pc) + ADDR_W'(4) && state == $past(state));

  a_r5_skip_keeps_state: assert property (@(posedge clk) disable iff (rst)
    retire && skip_vl0 |=> pc == $past(pc) + ADDR_W'(8) && state == $past(state));

  a_r5_skip_needs_prefix: assert property (@(posedge clk) disable iff (rst)
    skip_vl0 |-> is_prefixed);

  a_r8_held_pc_steps: assert property (@(posedge clk) disable iff (rst)
    retire && is_prefixed && next_pc == pc |=> src_step == $past(src_step) + 7'd1);

  a_r9_advance_clears_step: assert property (@(posedge clk) disable iff (rst)
    retire && is_prefixed && !skip_vl0 && next_pc != pc |=> src_step == 7'd0);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
    !retire |=> $stable(pc) && $stable(state));
endmodule

bind vloop_seq vloop_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .retire      (retire),
  .is_prefixed (is_prefixed),
  .skip_vl0    (skip_vl0),
  .src_step    (src_step),
  .next_pc     (next_pc),
  .pc          (pc),
  .state       (state)
);

// File: tb/vloop_seq_test.sv
`timescale 1ns/1ps
module vloop_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] init_pc = 64'h0;
  logic [31:0] init_state = 32'h0;
  logic [31:0] fetch_word = 32'h0;
  logic        retire = 1'b0;
  logic        src_vec = 1'b0, dst_vec = 1'b0, twin_pred = 1'b0;
  logic        is_prefixed, skip_vl0;
  logic [23:0] remap;
  logic [6:0]  src_step;
  logic [63:0] next_pc, pc;
  logic [31:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] m_pc;
  logic [31:0] m_state;
  logic [63:0] q_pc[$];
  logic [31:0] q_st[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  vloop_seq uut (
    .clk(clk), .rst(rst), .init_pc(init_pc), .init_state(init_state),
    .fetch_word(fetch_word), .retire(retire), .src_vec(src_vec),
    .dst_vec(dst_vec), .twin_pred(twin_pred), .is_prefixed(is_prefixed),
    .remap(remap), .src_step(src_step), .skip_vl0(skip_vl0),
    .next_pc(next_pc), .pc(pc), .state(state)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_st(input logic [6:0] mx, input logic [6:0] vl,
      input logic [6:0] ss, input logic [6:0] ds, input logic [1:0] sb, input logic [1:0] sk);
    return {mx, vl, ss, ds, sb, sk};
  endfunction

  // prefix word: major=1, marker bits 7 and 9 set, remap spread over 6,8,10..31
  function automatic logic [31:0] pfx_word(input logic [23:0] rm);
    return {6'd1, rm[23], 1'b1, rm[22], 1'b1, rm[21:0]};
  endfunction

  // monitor: pops expected register values one edge after each driven cycle
  initial begin
    forever begin
      @(negedge clk);
      if (q_pc.size() > 0) begin
        chk({q_tag[0], " pc"}, pc, q_pc.pop_front());
        chk({q_tag[0], " state"}, {32'h0, state}, {32'h0, q_st.pop_front()});
        void'(q_tag.pop_front());
      end
    end
  end

  task automatic step(input string tag, input logic [31:0] w, input logic ret,
                      input logic sv, input logic dv, input logic tw);
    logic pf, sk, cont, last;
    logic [6:0] vl, ss;
    logic [63:0] enp;
    logic [31:0] est;
    @(negedge clk);
    fetch_word = w; retire = ret; src_vec = sv; dst_vec = dv; twin_pred = tw;
    #1;
    pf   = (w[31:26] == 6'd1) && w[24] && w[22];
    vl   = m_state[24:18];
    ss   = m_state[17:11];
    sk   = pf && (vl == 7'd0);
    cont = tw ? (sv | dv) : dv;
    last = (ss == vl - 7'd1);
    est  = m_state;
    enp  = m_pc + (pf ? 64'd8 : 64'd4);
    if (pf && !sk) begin
      if (cont && !last) begin est[17:11] = ss + 7'd1; enp = m_pc; end
      else est[17:11] = 7'd0;
    end
    chk({tag, " is_prefixed (R1)"}, {63'h0, is_prefixed}, {63'h0, pf});
    chk({tag, " skip_vl0 (R5)"}, {63'h0, skip_vl0}, {63'h0, sk});
    chk({tag, " next_pc (R11)"}, next_pc, enp);
    chk({tag, " src_step (R4)"}, {57'h0, src_step}, {57'h0, ss});
    if (ret) begin m_pc = enp; m_state = est; end
    q_pc.push_back(m_pc);
    q_st.push_back(m_state);
    q_tag.push_back(tag);
  endtask

  task automatic do_reset(input logic [63:0] ipc, input logic [31:0] ist);
    @(negedge clk);
    rst = 1'b1; retire = 1'b0; init_pc = ipc; init_state = ist;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset pc", pc, ipc);
    chk("R10 reset state", {32'h0, state}, {32'h0, ist});
    m_pc = ipc; m_state = ist;
  endtask

  localparam logic [31:0] PLAIN = 32'h7C00_0214;
  localparam logic [23:0] RM_A  = 24'hA5_3C_96;

  initial begin
    do_reset(64'h1000, mk_st(7'd8, 7'd3, 7'd0, 7'd5, 2'd2, 2'd1));
    step("R3 plain", PLAIN, 1, 0, 1, 0);
    step("R1 near miss bit9 clear", 32'h0500_0000, 1, 0, 1, 0);
    step("R1 near miss bit7 clear", 32'h0440_0000, 1, 0, 1, 0);
    step("R1 wrong major", 32'h0D40_0000, 1, 0, 1, 0);
    // R2: remap extraction
    @(negedge clk); fetch_word = pfx_word(RM_A); retire = 0; #1;
    chk("R2 remap", {40'h0, remap}, {40'h0, RM_A});
    chk("R2 remap", {40'h0, remap}, {40'h0, RM_A});
    @(negedge clk); fetch_word = 32'h07FF_FFFF; #1;
    chk("R2 remap ones", {40'h0, remap}, {40'h0, 24'hFF_FFFF});
    // R6/R8/R9: single predication, vector dest, VL=3
    step("R8 step0", pfx_word(RM_A), 1, 0, 1, 0);
    step("R8 step1", pfx_word(RM_A), 1, 0, 1, 0);
    step("R9 last", pfx_word(RM_A), 1, 0, 1, 0);
    step("R4 fields kept", PLAIN, 1, 0, 0, 0);
    step("R6 src vec only ends", pfx_word(24'h0), 1, 1, 0, 0);
    // R7: twin predication
    step("R7 twin src vec", pfx_word(24'h1), 1, 1, 0, 1);
    step("R7 twin dst vec", pfx_word(24'h1), 1, 0, 1, 1);
    step("R7 twin scalar ends", pfx_word(24'h1), 1, 0, 0, 1);
    // R10: no retire, nothing moves
    step("R10 idle pfx", pfx_word(RM_A), 0, 0, 1, 0);
    step("R10 idle plain", PLAIN, 0, 0, 1, 0);
    // R5: VL=0 skip
    do_reset(64'h2000, mk_st(7'd4, 7'd0, 7'd2, 7'd1, 2'd0, 2'd3));
    step("R5 skip", pfx_word(RM_A), 1, 1, 1, 1);
    step("R5 skip again", pfx_word(24'h0), 1, 0, 1, 0);
    step("R3 plain after skip", PLAIN, 1, 0, 0, 0);
    // R8: modulo 128 wrap while held
    do_reset(64'h3000, mk_st(7'd127, 7'd5, 7'd127, 7'd0, 2'd1, 2'd0));
    step("R8 wrap", pfx_word(RM_A), 1, 0, 1, 0);
    step("R8 after wrap", pfx_word(RM_A), 1, 0, 1, 0);
    // VL=1: first step is last
    do_reset(64'h4000, mk_st(7'd1, 7'd1, 7'd0, 7'd0, 2'd0, 2'd0));
    step("R9 vl1", pfx_word(RM_A), 1, 0, 1, 0);
    @(negedge clk); retire = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule